// File: doc/BRIEF.md
# Control Register with Soft-Reset Sequencer

This block is one 32-bit control register for a memory-mapped peripheral. Software reaches it at four word offsets. Offset 0 is the ordinary read/write location. Offsets 1, 2 and 3 are write aliases that set, clear or invert only the bit positions marked by ones in the written mask. Every other bit keeps its value, so software never needs a read-modify-write. A parameter disables the aliases for registers that must not have them. In that variant, alias writes leave the register unchanged.

The top two bits control the peripheral:

- The most significant bit requests a soft reset. While it is 1, the block asserts a reset output to the peripheral.
- A small sequencer counts while the soft-reset bit is held. When the count completes, hardware sets the clock-gate bit (the next bit down) by itself. Software polls for that bit to confirm that the internal reset has finished.
- The peripheral enable output stands in for the real clock gate. It is high only when both control bits read 0.

Top module: `ctrl_reg_sreset`

## Requirements
- R1: On the asynchronous reset, the register reads 0xC000_0000, with the soft-reset bit (bit 31) and the clock-gate bit (bit 30) both 1. The reset output is then high and the enable output is low.
- R2: A write at word offset 0 replaces all 32 bits with the write data.
- R3: A write at word offset 1 sets to 1 every bit that is 1 in the data and leaves all other bits unchanged.
- R4: A write at word offset 2 clears to 0 every bit that is 1 in the data and leaves all other bits unchanged.
- R5: A write at word offset 3 inverts every bit that is 1 in the data and leaves all other bits unchanged.
- R6: With the alias parameter off, writes at offsets 1, 2 and 3 leave the register unchanged, and writes at offset 0 still work.
- R7: The reset output equals bit 31. The enable output is high only when bits 31 and 30 are both 0. The read data always shows the current register value, whatever the offset.
- R8: If bit 31 goes from 0 to 1 at clock edge E, bit 30 reads 1 from edge E+RST_CYCLES+1 onward, and not earlier unless the bus writes it.
- R9: Clearing bit 31 before the count completes aborts the sequence without setting bit 30. A later set of bit 31 restarts the full count.
- R10: If a bus write changes bit 30 in the same cycle that hardware sets it, the bus write wins.
- R11: Hardware sets bit 30 only once per period in which bit 31 is held at 1. Once software clears bit 30, it stays 0 while bit 31 remains 1.
- R12: The enable sequence leaves the peripheral enabled, with bits 31 and 30 both reading 0 right after their clearing writes. The sequence is: clear soft-reset, clear clock-gate, set soft-reset, poll until clock-gate is 1, clear soft-reset, clear clock-gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 2 | Word offset: 0 base, 1 set, 2 clear, 3 toggle |
| wdata_i | input | 32 | Write data or bit mask |
| rdata_o | output | 32 | Current register value |
| periph_rst_o | output | 1 | Reset to the peripheral, follows bit 31 |
| periph_en_o | output | 1 | Peripheral clock enable |

## Verification
The bench checks the exact cycle on which hardware sets the clock-gate bit. A sequencer that is off by one would make bit 30 appear one cycle early or late. It then drops the soft-reset bit partway through the count. A design that keeps its count across the gap would set the clock-gate bit early after the next request. The bench also lands a clearing write on the same edge as the hardware set, and clears bit 30 while soft-reset is still held. A design that let hardware win, or that re-armed the sequencer, would leave the bit reading 1. A second instance with aliases disabled shows whether alias writes leak into the register.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/ctrl_reg_wr_decode.sv
module ctrl_reg_wr_decode
  import ctrl_reg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter bit          ALIAS_EN = 1'b1
) (
  input  logic              wr_en_i,
  input  wr_op_e            op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] hit_o,
  output logic [DATA_W-1:0] val_o,
  output logic              tgl_o
);
  if (ALIAS_EN) begin : g_alias
    always_comb begin
      hit_o = '0;
      val_o = wdata_i;
      tgl_o = 1'b0;
      if (wr_en_i) begin
        unique case (op_i)
          OP_BASE: hit_o = '1;
          OP_SET: begin
            hit_o = wdata_i;
            val_o = '1;
          end
          OP_CLR: begin
            hit_o = wdata_i;
            val_o = '0;
          end
          OP_TGL: begin
            hit_o = wdata_i;
            tgl_o = 1'b1;
          end
          default: hit_o = '0;
        endcase
      end
    end
  end else begin : g_no_alias
    // alias offsets decode to no-ops
    always_comb begin
      hit_o = (wr_en_i && op_i == OP_BASE) ? '1 : '0;
      val_o = wdata_i;
      tgl_o = 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_reg_rst_seq.sv
module ctrl_reg_rst_seq #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  output logic set_cg_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!srst_i)         cnt_q <= '0;
    else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  // one strobe per held request; saturation stops re-arming
  assign set_cg_o = srst_i && (cnt_q == CNT_DONE);

  p_strobe_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cg_o |=> !set_cg_o);
  p_strobe_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cg_o |-> $past(srst_i));
endmodule

// File: rtl/ctrl_reg_sreset.sv
module ctrl_reg_sreset
  import ctrl_reg_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 8,
  parameter bit          ALIAS_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              periph_rst_o,
  output logic              periph_en_o
);
  localparam int unsigned SRST_BIT = DATA_W - 1;
  localparam int unsigned CG_BIT   = DATA_W - 2;
  localparam logic [DATA_W-1:0] RST_VAL = {2'b11, {(DATA_W-2){1'b0}}};

  logic [DATA_W-1:0] ctrl_q, ctrl_d, hit, val;
  logic              tgl, set_cg;
  wr_op_e            op;

  assign op = wr_op_e'(addr_i);

  ctrl_reg_wr_decode #(.DATA_W(DATA_W), .ALIAS_EN(ALIAS_EN)) i_decode (
    .wr_en_i (wr_en_i),
    .op_i    (op),
    .wdata_i (wdata_i),
    .hit_o   (hit),
    .val_o   (val),
    .tgl_o   (tgl)
  );

  ctrl_reg_rst_seq #(.RST_CYCLES(RST_CYCLES)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (ctrl_q[SRST_BIT]),
    .set_cg_o (set_cg)
  );

  // bus write takes priority over the hardware clock-gate set
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == CG_BIT) begin : g_cg
      assign ctrl_d[i] = hit[i] ? (tgl ? ~ctrl_q[i] : val[i]) : (ctrl_q[i] | set_cg);
    end else begin : g_plain
      assign ctrl_d[i] = hit[i] ? (tgl ? ~ctrl_q[i] : val[i]) : ctrl_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= RST_VAL;
    else         ctrl_q <= ctrl_d;
  end

  assign rdata_o      = ctrl_q;
  assign periph_rst_o = ctrl_q[SRST_BIT];
  assign periph_en_o  = !ctrl_q[SRST_BIT] && !ctrl_q[CG_BIT];

  p_base_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> rdata_o == $past(wdata_i));

  p_hw_cg_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_cg && !(wr_en_i && hit[CG_BIT])) |=> rdata_o[CG_BIT]);

  if (ALIAS_EN) begin : g_alias_chk
    p_set_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 2'd1) |=> (rdata_o & $past(wdata_i)) == $past(wdata_i));
    p_clr_alias_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 2'd2) |=> (rdata_o & $past(wdata_i)) == '0);
    p_tgl_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 2'd3) |=>
        ((rdata_o ^ $past(rdata_o)) & $past(wdata_i)) == $past(wdata_i));
  end else begin : g_no_alias_chk
    p_alias_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i != 2'd0 && !set_cg) |=> $stable(rdata_o));
  end
endmodule

// File: tb/test_ctrl_reg_sreset.sv
module test_ctrl_reg_sreset;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        prst_a, pen_a, prst_b, pen_b;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_reg_sreset #(.RST_CYCLES(N), .ALIAS_EN(1'b1)) i_ctrl_reg_sreset (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_a), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_a), .periph_rst_o(prst_a), .periph_en_o(pen_a));

  ctrl_reg_sreset #(.RST_CYCLES(N), .ALIAS_EN(1'b0)) i_ctrl_reg_sreset_na (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_b), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_b), .periph_rst_o(prst_b), .periph_en_o(pen_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input bit tgt_b, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (tgt_b) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 value", rd_a, 32'hC000_0000);
    chk("R1 rst_o", 32'(prst_a), 32'd1);
    chk("R1 en_o", 32'(pen_a), 32'd0);
    chk("R1 na value", rd_b, 32'hC000_0000);
  endtask

  task automatic t_alias;
    wr(0, 2'd0, 32'h1234_0000);
    chk("R2 base", rd_a, 32'h1234_0000);
    chk("R7 en after base", 32'(pen_a), 32'd1);
    wr(0, 2'd1, 32'h0000_00FF);
    chk("R3 set", rd_a, 32'h1234_00FF);
    wr(0, 2'd2, 32'h0030_000F);
    chk("R4 clear", rd_a, 32'h1204_00F0);
    wr(0, 2'd3, 32'h0000_0FF0);
    chk("R5 toggle", rd_a, 32'h1204_0F00);
    addr = 2'd3;
    tick(1);
    chk("R7 read at alias", rd_a, 32'h1204_0F00);
  endtask

  task automatic t_no_alias;
    wr(1, 2'd0, 32'h0000_1234);
    chk("R6 base", rd_b, 32'h0000_1234);
    wr(1, 2'd1, 32'h0000_00FF);
    chk("R6 set ignored", rd_b, 32'h0000_1234);
    wr(1, 2'd2, 32'hFFFF_FFFF);
    chk("R6 clear ignored", rd_b, 32'h0000_1234);
    wr(1, 2'd3, 32'hFFFF_FFFF);
    chk("R6 toggle ignored", rd_b, 32'h0000_1234);
    chk("R6 en stays", 32'(pen_b), 32'd1);
  endtask

  task automatic t_seq_timing;
    wr(0, 2'd0, 32'h0);
    wr(0, 2'd1, 32'h8000_0000);   // edge E
    chk("R7 rst_o on srst", 32'(prst_a), 32'd1);
    chk("R7 en_o off on srst", 32'(pen_a), 32'd0);
    tick(N);                       // after E+N
    chk("R8 cg not yet", 32'(rd_a[30]), 32'd0);
    tick(1);                       // after E+N+1
    chk("R8 cg set", 32'(rd_a[30]), 32'd1);
  endtask

  task automatic t_abort;
    wr(0, 2'd0, 32'h0);
    wr(0, 2'd1, 32'h8000_0000);
    tick(3);
    wr(0, 2'd2, 32'h8000_0000);
    tick(N + 3);
    chk("R9 aborted no cg", rd_a, 32'h0);
    wr(0, 2'd1, 32'h8000_0000);
    tick(N);
    chk("R9 restart full count", 32'(rd_a[30]), 32'd0);
    tick(1);
    chk("R9 restart sets cg", 32'(rd_a[30]), 32'd1);
  endtask

  task automatic t_collide;
    wr(0, 2'd0, 32'h0);
    wr(0, 2'd1, 32'h8000_0000);   // edge E
    tick(N - 1);
    wr(0, 2'd2, 32'h4000_0000);   // lands on edge E+N+1
    chk("R10 bus wins", rd_a, 32'h8000_0000);
    tick(5);
    chk("R11 no re-set", rd_a, 32'h8000_0000);
  endtask

  task automatic t_enable;
    int polls = 0;
    wr(0, 2'd2, 32'h8000_0000);
    chk("R12 srst reads 0", 32'(rd_a[31]), 32'd0);
    wr(0, 2'd2, 32'h4000_0000);
    wr(0, 2'd1, 32'h8000_0000);
    while (!rd_a[30] && polls < 100) begin
      tick(1);
      polls++;
    end
    chk("R12 cg polled", 32'(rd_a[30]), 32'd1);
    wr(0, 2'd2, 32'h8000_0000);
    chk("R12 srst cleared", 32'(rd_a[31]), 32'd0);
    wr(0, 2'd2, 32'h4000_0000);
    chk("R12 cg cleared", 32'(rd_a[30]), 32'd0);
    chk("R12 enabled", 32'(pen_a), 32'd1);
    chk("R12 reset released", 32'(prst_a), 32'd0);
  endtask

  initial begin
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_alias;
    t_no_alias;
    t_seq_timing;
    t_abort;
    t_collide;
    t_enable;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule